// File: doc/BRIEF.md
# Synchronous Flow-Through Burst SRAM

This block is a single-clock synchronous static RAM with its own burst address generator. Words are built from four 9-bit byte lanes, 36 bits in all. Address, strobes, chip enables, write controls and write data are all registered on the rising clock edge. Read data is flow-through: the array output for the registered address reaches the output before the following edge, with no output register in between. Depth is set by `ADDR_W`. The default is small so that the model elaborates quickly; set `ADDR_W` to 17 for 131,072 words.

A burst begins on either of two address strobes, which load the external address. One strobe is meant for a processor and one for a cache controller. After that, an advance input steps a 2-bit counter. The counter replaces only the two low address bits, in linear order (modulo 4) or in interleaved order (XOR with the loaded low bits). The order is taken from the mode pin when the burst starts.

Writes update only the lanes that the byte strobes select, or all lanes when the global write input is asserted. The shared data bus is split into input, output and output enable, as pads on a chip usually are. The enable is high only while the device is driving read data.

Top module: `sync_burst_sram`

## Requirements
- R1: Read data is flow-through. When a cycle's address is registered on edge N and no write is requested, `dq_o` carries that word with `dq_oe` high before edge N+1.
- R2: The processor strobe (`adsp_n` low) starts a burst only while `ce1_n` is low. It then loads `addr_i` and clears the counter. While `ce1_n` is high, that strobe is ignored and the current burst address is unchanged.
- R3: The controller strobe (`adsc_n` low) starts an active burst only when `ce1_n`, `ce2_n` and `ce3_n` are all low. A start with any enable high deselects the device from the next cycle: `dq_oe` is low and write requests leave the array unchanged.
- R4: Without a start, the counter steps by one when `adv_n` is low and holds when `adv_n` is high. Only address bits [1:0] ever change within a burst.
- R5: With `mode_i` low at the start, the low address bits follow base+count modulo 4, so a burst from ...2 visits 2,3,0,1.
- R6: With `mode_i` high at the start, the low address bits are base XOR count, so a burst from ...1 visits 1,0,3,2.
- R7: When `gw_n` is high and `bwe_n` is low, only the lanes whose `bw_n[i]` is low are written. Lane i is bits [9i+8:9i].
- R8: When `gw_n` is low, all four lanes are written, whatever the values of `bwe_n` and `bw_n`.
- R9: After reset the device is deselected with `dq_oe` low. `dq_oe` stays low in every write cycle and in every deselected cycle.
- R10: A write requested in one cycle is committed on the edge that begins the next cycle. A read started in that next cycle at the same address returns the merged new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low, clears burst state |
| addr_i | input | ADDR_W | External word address |
| adsp_n | input | 1 | Processor address strobe, active low |
| adsc_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| mode_i | input | 1 | Burst order: 0 linear, 1 interleaved |
| ce1_n | input | 1 | Chip enable 1, active low |
| ce2_n | input | 1 | Chip enable 2, active low |
| ce3_n | input | 1 | Chip enable 3, active low |
| gw_n | input | 1 | Global write of all lanes, active low |
| bwe_n | input | 1 | Byte write enable, active low |
| bw_n | input | LANES | Per-lane byte write strobes, active low |
| dq_i | input | LANES*LANE_W | Data bus input side, write data |
| dq_o | output | LANES*LANE_W | Data bus output side, read data |
| dq_oe | output | 1 | Data bus drive enable |

## Verification
A write commit and a new burst start can land on the same edge. The write captured in the previous cycle lands in the array on the same edge that registers a fresh strobe for a read of that word. The bench provokes this with a byte-lane write followed directly by a read start at the same address, and again with a global write that also carries byte strobes. The scoreboard judges the read-back word against a lane-merged value that its own model predicts. A second overlap is a strobe that arrives mid-burst and must be ignored, because `ce1_n` is high while the advance input holds the counter. The bench checks that the output word stays on the old burst address.

// File: rtl/sync_burst_sram.sv
module sync_burst_sram #(
  parameter int ADDR_W = 10,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic                      adsp_n,
  input  logic                      adsc_n,
  input  logic                      adv_n,
  input  logic                      mode_i,
  input  logic                      ce1_n,
  input  logic                      ce2_n,
  input  logic                      ce3_n,
  input  logic                      gw_n,
  input  logic                      bwe_n,
  input  logic [LANES-1:0]          bw_n,
  input  logic [LANES*LANE_W-1:0]   dq_i,
  output logic [LANES*LANE_W-1:0]   dq_o,
  output logic                      dq_oe
);
  localparam int DATA_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  logic              act_q;
  logic [ADDR_W-1:0] base_q;
  logic [1:0]        cnt_q;
  logic              mode_q;
  logic [LANES-1:0]  wl_q;
  logic [DATA_W-1:0] wd_q;

  wire all_ce = !ce1_n && !ce2_n && !ce3_n;
  wire p_go   = !adsp_n && !ce1_n;
  wire c_go   = !adsc_n && !p_go;
  wire start  = p_go || c_go;

  wire [LANES-1:0]  wl  = !gw_n ? '1 : (!bwe_n ? ~bw_n : '0);
  wire [1:0]        lo  = mode_q ? (base_q[1:0] ^ cnt_q) : (base_q[1:0] + cnt_q);
  wire [ADDR_W-1:0] cur = {base_q[ADDR_W-1:2], lo};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      base_q <= '0;
      cnt_q  <= '0;
      mode_q <= 1'b0;
      wl_q   <= '0;
      wd_q   <= '0;
    end else begin
      if (start) begin
        act_q  <= all_ce;
        base_q <= addr_i;
        cnt_q  <= '0;
        mode_q <= mode_i;
      end else if (!adv_n && act_q) begin
        cnt_q  <= cnt_q + 2'd1;
      end
      wl_q <= wl;
      wd_q <= dq_i;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++)
      if (act_q && wl_q[i])
        mem[cur][i*LANE_W +: LANE_W] <= wd_q[i*LANE_W +: LANE_W];
  end

  assign dq_o  = mem[cur];
  assign dq_oe = act_q && (wl_q == '0);
endmodule

// File: rtl/sync_burst_sram_chk.sv
module sync_burst_sram_chk #(
  parameter int ADDR_W = 10,
  parameter int LANES  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr_i,
  input logic              adsp_n,
  input logic              adsc_n,
  input logic              adv_n,
  input logic              ce1_n,
  input logic              ce2_n,
  input logic              ce3_n,
  input logic              gw_n,
  input logic              act_q,
  input logic [ADDR_W-1:0] base_q,
  input logic [1:0]        cnt_q,
  input logic [LANES-1:0]  wl_q,
  input logic              dq_oe
);
  assert_adsp_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!adsp_n && !ce1_n) |=> (base_q == $past(addr_i) && cnt_q == 2'd0));

  assert_adsc_deselect_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((adsp_n || ce1_n) && !adsc_n && (ce1_n || ce2_n || ce3_n)) |=> !act_q);

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((adsp_n || ce1_n) && adsc_n && adv_n) |=> ($stable(cnt_q) && $stable(base_q)));

  assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((adsp_n || ce1_n) && adsc_n && !adv_n && act_q) |=> (cnt_q == $past(cnt_q) + 2'd1));

  assert_global_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !gw_n |=> (wl_q == '1));

  assert_quiet_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !act_q |-> !dq_oe);
endmodule

bind sync_burst_sram sync_burst_sram_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) chk_i (
  .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .adsp_n(adsp_n), .adsc_n(adsc_n),
  .adv_n(adv_n), .ce1_n(ce1_n), .ce2_n(ce2_n), .ce3_n(ce3_n), .gw_n(gw_n),
  .act_q(act_q), .base_q(base_q), .cnt_q(cnt_q), .wl_q(wl_q), .dq_oe(dq_oe)
);

// File: tb/sync_burst_sram_tb_top.sv
`timescale 1ns/100ps
module sync_burst_sram_tb_top;
  localparam int AW = 10;
  localparam int DW = 36;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic          adsp_n = 1'b1, adsc_n = 1'b1, adv_n = 1'b1, mode_i = 1'b0;
  logic          ce1_n = 1'b0, ce2_n = 1'b0, ce3_n = 1'b0;
  logic          gw_n = 1'b1, bwe_n = 1'b1;
  logic [3:0]    bw_n = 4'hF;
  logic [DW-1:0] dq_i = '0;
  logic [DW-1:0] dq_o;
  logic          dq_oe;

  always #2.5 clk = ~clk;

  sync_burst_sram #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .adsp_n(adsp_n), .adsc_n(adsc_n),
    .adv_n(adv_n), .mode_i(mode_i), .ce1_n(ce1_n), .ce2_n(ce2_n), .ce3_n(ce3_n),
    .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n), .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  bit            q_oe[$];
  bit            q_dat[$];
  logic [DW-1:0] q_d[$];
  string         q_tag[$];

  logic [DW-1:0] ref_mem [int];
  bit            r_act = 0;
  logic [AW-1:0] r_base = '0;
  logic [1:0]    r_cnt = '0;
  bit            r_mode = 0;
  bit            p_en = 0;
  logic [AW-1:0] p_a = '0;
  logic [3:0]    p_l = '0;
  logic [DW-1:0] p_d = '0;

  task automatic check(bit ok, string tag, logic [DW-1:0] got, logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic step(bit sp, bit sc, bit adv, logic [AW-1:0] a, bit c1, bit c2, bit c3,
                      bit gw, bit bwe, logic [3:0] bw, logic [DW-1:0] wd, bit md, string tag);
    logic [3:0]    ln;
    logic [1:0]    lo;
    logic [AW-1:0] ca;
    logic [DW-1:0] w;
    bit            pg, cg;
    @(negedge clk);
    if (p_en) begin
      w = ref_mem.exists(int'(p_a)) ? ref_mem[int'(p_a)] : '0;
      for (int i = 0; i < 4; i++) if (p_l[i]) w[i*9 +: 9] = p_d[i*9 +: 9];
      ref_mem[int'(p_a)] = w;
    end
    pg = !sp && !c1;
    cg = !sc && !pg;
    if (pg || cg) begin
      r_act = !c1 && !c2 && !c3; r_base = a; r_cnt = 0; r_mode = md;
    end else if (!adv && r_act) r_cnt = r_cnt + 2'd1;
    ln = !gw ? 4'hF : (!bwe ? ~bw : 4'h0);
    lo = r_mode ? (r_base[1:0] ^ r_cnt) : (r_base[1:0] + r_cnt);
    ca = {r_base[AW-1:2], lo};
    q_oe.push_back(r_act && ln == 0);
    q_dat.push_back(r_act && ln == 0 && ref_mem.exists(int'(ca)));
    q_d.push_back(ref_mem.exists(int'(ca)) ? ref_mem[int'(ca)] : '0);
    q_tag.push_back(tag);
    p_en = r_act && ln != 0; p_a = ca; p_l = ln; p_d = wd;
    adsp_n = sp; adsc_n = sc; adv_n = adv; addr_i = a;
    ce1_n = c1; ce2_n = c2; ce3_n = c3; gw_n = gw; bwe_n = bwe; bw_n = bw;
    dq_i = wd; mode_i = md;
  endtask

  task automatic rd_c(logic [AW-1:0] a, bit md, string tag);
    step(1, 0, 1, a, 0, 0, 0, 1, 1, 4'hF, '0, md, tag);
  endtask
  task automatic adv_rd(string tag);
    step(1, 1, 0, '0, 0, 0, 0, 1, 1, 4'hF, '0, 0, tag);
  endtask

  initial begin : monitor
    bit oe, dc;
    logic [DW-1:0] d;
    string t;
    forever begin
      @(posedge clk);
      #1.5;
      if (q_oe.size() != 0) begin
        oe = q_oe.pop_front(); dc = q_dat.pop_front(); d = q_d.pop_front(); t = q_tag.pop_front();
        check(dq_oe == oe, {t, " dq_oe"}, {35'd0, dq_oe}, {35'd0, oe});
        if (dc) check(dq_o == d, {t, " dq_o"}, dq_o, d);
      end
    end
  end

  initial begin : watchdog
    #(5.0 * 20000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    #1;
    check(dq_oe == 1'b0, "R9 reset", {35'd0, dq_oe}, '0);
    @(negedge clk) rst_n = 1'b1;
    // R8/R5: global-write burst 0x10..0x13
    step(1, 0, 1, 10'h010, 0, 0, 0, 0, 1, 4'hF, 36'h1_1111_1110, 0, "R8");
    step(1, 1, 0, '0, 0, 0, 0, 0, 1, 4'hF, 36'h2_2222_2221, 0, "R5");
    step(1, 1, 0, '0, 0, 0, 0, 0, 1, 4'hF, 36'h3_3333_3332, 0, "R5");
    step(1, 1, 0, '0, 0, 0, 0, 0, 1, 4'hF, 36'h4_4444_4443, 0, "R5");
    // R2/R5/R1: processor-strobe linear read from 0x12
    step(0, 1, 1, 10'h012, 0, 0, 0, 1, 1, 4'hF, '0, 0, "R2");
    adv_rd("R5"); adv_rd("R5"); adv_rd("R1");
    // R6: interleaved from 0x11
    rd_c(10'h011, 1, "R6");
    adv_rd("R6"); adv_rd("R6"); adv_rd("R6");
    // R4: hold
    step(1, 1, 1, 10'h3FF, 0, 0, 0, 1, 1, 4'hF, '0, 0, "R4");
    step(1, 1, 1, 10'h155, 0, 0, 0, 1, 1, 4'hF, '0, 0, "R4");
    // R7/R10: lanes 0 and 2 written, then read straight after
    step(1, 0, 1, 10'h012, 0, 0, 0, 1, 0, 4'b1010, 36'hA_BCDE_F012, 0, "R7");
    rd_c(10'h012, 0, "R10");
    // R8/R10: global write overrides byte strobes
    step(1, 0, 1, 10'h013, 0, 0, 0, 0, 0, 4'b1110, 36'h5_A5A5_A5A5, 0, "R8");
    rd_c(10'h013, 0, "R10");
    // R2: processor strobe ignored while ce1_n high
    rd_c(10'h010, 0, "R1");
    step(0, 1, 1, 10'h2A0, 1, 0, 0, 1, 1, 4'hF, '0, 0, "R2");
    adv_rd("R4");
    // R3: deselect, write attempt ignored
    step(1, 0, 1, 10'h010, 0, 1, 0, 1, 1, 4'hF, '0, 0, "R3");
    step(1, 1, 0, '0, 0, 0, 0, 0, 1, 4'hF, 36'hF_FFFF_FFFF, 0, "R3");
    step(0, 1, 1, 10'h011, 0, 0, 1, 0, 1, 4'hF, 36'hE_EEEE_EEEE, 0, "R3");
    step(0, 0, 1, 10'h011, 1, 0, 0, 1, 1, 4'hF, '0, 0, "R3");
    rd_c(10'h010, 0, "R3");
    rd_c(10'h011, 0, "R3");
    // R5: linear wrap from 0x13
    step(0, 1, 1, 10'h013, 0, 0, 0, 1, 1, 4'hF, '0, 0, "R5");
    adv_rd("R5");
    step(1, 1, 1, '0, 0, 0, 0, 1, 1, 4'hF, '0, 0, "R9");
    @(posedge clk);
    #2;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule